// File: doc/BRIEF.md
# Pipelined-SAR Phase Sequencer

This block is the control state machine of a two-stage pipelined successive-approximation converter. It produces only digital enables and strobes: a reset and a start for the coarse SAR, sample and hold switch enables for two sampling capacitor DACs, a clock and a destination select for a single dynamic amplifier, and start strobes for the two fine SARs. It does not model any analog behaviour.

A conversion runs as a chain of phases, and each phase is closed by a completion pulse from the circuit it started. The coarse SAR is cleared and the input is sampled on the active DAC. The coarse conversion then runs. The coarse code is loaded into the DAC with a half-LSB upward shift, the shared amplifier amplifies that residue, and fine SAR A is started. When A has its sample, the DAC is shifted half an LSB down, the amplifier amplifies again, and fine SAR B is started. When B finishes, a one-cycle valid strobe reports the DAC index used, and the next conversion uses the other DAC. If an expected completion pulse does not arrive, a watchdog returns the machine to idle.

Top module: `psar_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it is released, every output is low. After a reset, the next conversion uses DAC 0.
- R2: A high `conv_req` in idle gives a one-cycle `sar1_rst`. Then the active DAC's sample enable is 2'b11 for `SAMP_CYC` cycles. Then `sar1_start` is high for one cycle with the sample enable low.
- R3: After `sar1_done`, the active DAC's hold enable is 2'b01 (code loaded, shifted up) and `amp_clk` is high with `amp_sel` = 0, until `amp_done`. Then `sara_start` is high for one cycle with `amp_clk` low.
- R4: After `sara_done`, the hold enable is 2'b10 (shifted down) and `amp_clk` is high with `amp_sel` = 1, until `amp_done`. Then `sarb_start` is high for one cycle. The amplifier clock is never high together with a fine-SAR start.
- R5: After `sarb_done`, `conv_valid` is high for exactly one cycle and `conv_dac` gives the DAC index used (0 or 1). Successive completed conversions alternate between DAC 0 and DAC 1.
- R6: A DAC never has a sample enable and a hold enable active at once. The DAC that is not active has all its enables low.
- R7: A completion pulse that does not belong to the phase being waited on has no effect on any output.
- R8: If a waiting phase (coarse conversion, either amplification, either fine conversion) gets no completion pulse within `TMO` cycles, the machine returns to idle. A completion pulse in the last cycle of that window is still accepted. After a timeout, no valid strobe is given and the next conversion reuses the same DAC.
- R9: `conv_req` is ignored while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Request a conversion (taken in idle) |
| sar1_done | input | 1 | Coarse SAR finished |
| amp_done | input | 1 | Amplifier phase finished |
| sara_done | input | 1 | Fine SAR A finished |
| sarb_done | input | 1 | Fine SAR B finished |
| sar1_rst | output | 1 | Coarse SAR clear strobe |
| sar1_start | output | 1 | Coarse SAR start strobe |
| sara_start | output | 1 | Fine SAR A start strobe |
| sarb_start | output | 1 | Fine SAR B start strobe |
| amp_clk | output | 1 | Dynamic amplifier clock |
| amp_sel | output | 1 | Amplifier destination: 0 = SAR A, 1 = SAR B |
| dac0_samp | output | 2 | DAC 0 sample switch enables |
| dac0_hold | output | 2 | DAC 0 hold enables: bit 0 up-shift, bit 1 down-shift |
| dac1_samp | output | 2 | DAC 1 sample switch enables |
| dac1_hold | output | 2 | DAC 1 hold enables: bit 0 up-shift, bit 1 down-shift |
| conv_valid | output | 1 | Conversion complete strobe |
| conv_dac | output | 1 | DAC index of the completed conversion |

## Verification
The hardest situations to reach are the edges of the watchdog window and stray completion pulses. A pulse in the last cycle before the timeout must still be accepted. A pulse one cycle later must be ignored, and the DAC must not toggle. To get there, the bench drives the done inputs itself with per-phase latencies taken from a table, including latencies of exactly `TMO`-1. During the wait for SAR A, it drives every unrelated done pulse and the request together. It also lets the coarse phase expire, then sends a late done pulse and checks which DAC the next conversion uses.

// File: rtl/psar_phase_seq.sv
module psar_phase_seq #(
  parameter int SAMP_CYC = 4,
  parameter int TMO      = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       conv_req,
  input  logic       sar1_done,
  input  logic       amp_done,
  input  logic       sara_done,
  input  logic       sarb_done,
  output logic       sar1_rst,
  output logic       sar1_start,
  output logic       sara_start,
  output logic       sarb_start,
  output logic       amp_clk,
  output logic       amp_sel,
  output logic [1:0] dac0_samp,
  output logic [1:0] dac0_hold,
  output logic [1:0] dac1_samp,
  output logic [1:0] dac1_hold,
  output logic       conv_valid,
  output logic       conv_dac
);

  localparam int LIM = (TMO > SAMP_CYC) ? TMO : SAMP_CYC;
  localparam int CW  = $clog2(LIM) + 1;

  typedef enum logic [3:0] {
    IDLE, CLR1, SAMP, GO1, WAIT1, AMPU, GOA, WAITA, AMPD, GOB, WAITB, DONE
  } st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt;
  logic          act;
  logic          waiting, expired, hold_up, hold_dn, samp;

  assign waiting = (st == WAIT1) || (st == AMPU) || (st == WAITA) ||
                   (st == AMPD)  || (st == WAITB);
  assign expired = waiting && (cnt == CW'(TMO - 1));

  always_comb begin
    st_n = st;
    case (st)
      IDLE:  if (conv_req) st_n = CLR1;
      CLR1:  st_n = SAMP;
      SAMP:  if (cnt == CW'(SAMP_CYC - 1)) st_n = GO1;
      GO1:   st_n = WAIT1;
      WAIT1: if (sar1_done) st_n = AMPU; else if (expired) st_n = IDLE;
      AMPU:  if (amp_done)  st_n = GOA;  else if (expired) st_n = IDLE;
      GOA:   st_n = WAITA;
      WAITA: if (sara_done) st_n = AMPD; else if (expired) st_n = IDLE;
      AMPD:  if (amp_done)  st_n = GOB;  else if (expired) st_n = IDLE;
      GOB:   st_n = WAITB;
      WAITB: if (sarb_done) st_n = DONE; else if (expired) st_n = IDLE;
      DONE:  st_n = IDLE;
      default: st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= IDLE;
      cnt <= '0;
      act <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= (st_n != st || st == IDLE) ? '0 : cnt + 1'b1;
      if (st == DONE) act <= ~act;
    end
  end

  assign samp       = (st == SAMP);
  assign hold_up    = (st == AMPU) || (st == GOA) || (st == WAITA);
  assign hold_dn    = (st == AMPD) || (st == GOB) || (st == WAITB);

  assign sar1_rst   = (st == CLR1);
  assign sar1_start = (st == GO1);
  assign sara_start = (st == GOA);
  assign sarb_start = (st == GOB);
  assign amp_clk    = (st == AMPU) || (st == AMPD);
  assign amp_sel    = (st == AMPD);
  assign dac0_samp  = {2{samp & ~act}};
  assign dac1_samp  = {2{samp &  act}};
  assign dac0_hold  = act ? 2'b00 : {hold_dn, hold_up};
  assign dac1_hold  = act ? {hold_dn, hold_up} : 2'b00;
  assign conv_valid = (st == DONE);
  assign conv_dac   = conv_valid & act;

  assert_clean_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !(sar1_rst || sar1_start || sara_start || sarb_start || amp_clk ||
                     conv_valid || (|dac0_samp) || (|dac0_hold) || (|dac1_samp) || (|dac1_hold)));

  assert_sara_after_amp_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sara_start) |-> $past(amp_done) && $past(amp_clk) && !$past(amp_sel));

  assert_sarb_after_amp_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sarb_start) |-> $past(amp_done) && $past(amp_sel));

  assert_amp_not_with_start_R4: assert property (@(posedge clk) disable iff (rst)
    amp_clk |-> !(sara_start || sarb_start || sar1_start));

  assert_valid_after_b_R5: assert property (@(posedge clk) disable iff (rst)
    conv_valid |-> $past(sarb_done) && !$past(conv_valid));

  assert_no_samp_hold_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !((|dac0_samp) && (|dac0_hold)) && !((|dac1_samp) && (|dac1_hold)));

  assert_one_dac_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(((|dac0_samp) || (|dac0_hold)) && ((|dac1_samp) || (|dac1_hold))));

  assert_watchdog_bound_R8: assert property (@(posedge clk) disable iff (rst)
    waiting |-> cnt < CW'(TMO));

endmodule

// File: tb/psar_phase_seq_test.sv
module psar_phase_seq_test;
  localparam int SAMP = 3;
  localparam int TMO  = 16;
  localparam int NV   = 6;
  // per row: coarse wait, amp-up wait, SAR A wait, amp-down wait, SAR B wait, noise
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 0, 0, 0},
    '{3, 1, 5, 2, 4, 0},
    '{TMO-1, 0, 0, 0, 0, 0},
    '{0, TMO-1, 2, TMO-1, 0, 1},
    '{1, 1, TMO-1, 1, TMO-1, 0},
    '{7, 2, 3, 4, 5, 1}
  };

  logic clk = 0, rst = 1, conv_req = 0;
  logic sar1_done = 0, amp_done = 0, sara_done = 0, sarb_done = 0;
  logic sar1_rst, sar1_start, sara_start, sarb_start, amp_clk, amp_sel;
  logic [1:0] dac0_samp, dac0_hold, dac1_samp, dac1_hold;
  logic conv_valid, conv_dac;
  int tests = 0, fails = 0;
  bit finished = 0;

  psar_phase_seq #(.SAMP_CYC(SAMP), .TMO(TMO)) uut (
    .clk(clk), .rst(rst), .conv_req(conv_req), .sar1_done(sar1_done),
    .amp_done(amp_done), .sara_done(sara_done), .sarb_done(sarb_done),
    .sar1_rst(sar1_rst), .sar1_start(sar1_start), .sara_start(sara_start),
    .sarb_start(sarb_start), .amp_clk(amp_clk), .amp_sel(amp_sel),
    .dac0_samp(dac0_samp), .dac0_hold(dac0_hold), .dac1_samp(dac1_samp),
    .dac1_hold(dac1_hold), .conv_valid(conv_valid), .conv_dac(conv_dac));

  always #10 clk = ~clk;

  function automatic logic [1:0] samp_of(input logic d);
    return d ? dac1_samp : dac0_samp;
  endfunction
  function automatic logic [1:0] hold_of(input logic d);
    return d ? dac1_hold : dac0_hold;
  endfunction
  function automatic logic all_low();
    return {sar1_rst, sar1_start, sara_start, sarb_start, amp_clk, amp_sel,
            dac0_samp, dac0_hold, dac1_samp, dac1_hold, conv_valid, conv_dac} == '0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic conv(input int d1, input int da1, input int dsa, input int da2,
                      input int dsb, input int noise, input logic e);
    conv_req = 1; @(negedge clk); conv_req = 0;
    chk(sar1_rst == 1, "R2 clear strobe", sar1_rst, 1);
    for (int i = 0; i < SAMP; i++) begin
      @(negedge clk);
      chk(samp_of(e) == 2'b11 && hold_of(e) == 2'b00, "R2 sample", samp_of(e), 3);
      chk(samp_of(!e) == 0 && hold_of(!e) == 0, "R6 idle dac", {samp_of(!e), hold_of(!e)}, 0);
    end
    @(negedge clk);
    chk(sar1_start == 1 && samp_of(e) == 0, "R2 coarse start", sar1_start, 1);
    @(negedge clk);
    repeat (d1) @(negedge clk);
    sar1_done = 1; @(negedge clk); sar1_done = 0;
    chk(hold_of(e) == 2'b01 && samp_of(e) == 0, "R3 up-shift hold", hold_of(e), 1);
    chk(amp_clk == 1 && amp_sel == 0, "R3 amp to A", {amp_clk, amp_sel}, 2);
    repeat (da1) @(negedge clk);
    amp_done = 1; @(negedge clk); amp_done = 0;
    chk(sara_start == 1 && amp_clk == 0, "R3 start A", sara_start, 1);
    @(negedge clk);
    for (int i = 0; i < dsa; i++) begin
      if (noise != 0) begin
        conv_req = 1; sar1_done = 1; amp_done = 1; sarb_done = 1;
      end
      @(negedge clk);
      conv_req = 0; sar1_done = 0; amp_done = 0; sarb_done = 0;
      if (noise != 0) begin
        chk(hold_of(e) == 2'b01 && !amp_clk && !sarb_start, "R7 stray done", hold_of(e), 1);
        chk(sar1_rst == 0 && samp_of(e) == 0, "R9 busy request", sar1_rst, 0);
      end
    end
    sara_done = 1; @(negedge clk); sara_done = 0;
    chk(hold_of(e) == 2'b10, "R4 down-shift hold", hold_of(e), 2);
    chk(amp_clk == 1 && amp_sel == 1, "R4 amp to B", {amp_clk, amp_sel}, 3);
    repeat (da2) @(negedge clk);
    amp_done = 1; @(negedge clk); amp_done = 0;
    chk(sarb_start == 1 && amp_clk == 0, "R4 start B", sarb_start, 1);
    @(negedge clk);
    repeat (dsb) @(negedge clk);
    sarb_done = 1; @(negedge clk); sarb_done = 0;
    chk(conv_valid == 1 && conv_dac == e, "R5 valid and dac", {conv_valid, conv_dac}, {1'b1, e});
    @(negedge clk);
    chk(conv_valid == 0 && all_low(), "R5 single valid", conv_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(all_low(), "R1 during reset", 1, 0);
    rst = 0;
    @(negedge clk);
    chk(all_low(), "R1 after release", 1, 0);

    for (int v = 0; v < NV; v++)
      conv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], logic'(v % 2));

    // R8: let the coarse phase expire, then send a late done
    conv_req = 1; @(negedge clk); conv_req = 0;
    repeat (SAMP) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    repeat (TMO) @(negedge clk);
    chk(all_low(), "R8 timeout idle", 1, 0);
    sar1_done = 1; @(negedge clk); sar1_done = 0;
    chk(all_low() && hold_of(0) == 0, "R8 late done ignored", hold_of(0), 0);
    repeat (2) @(negedge clk);
    chk(all_low(), "R8 no valid after timeout", conv_valid, 0);
    conv(0, 0, 0, 0, 0, 0, 1'b0);  // R8: DAC 0 reused after timeout
    conv(1, 0, 1, 0, 1, 0, 1'b1);
    conv(0, 1, 0, 1, 0, 0, 1'b0);

    // R1: reset in the middle of a conversion on DAC 1
    conv_req = 1; @(negedge clk); conv_req = 0;
    repeat (SAMP + 2) @(negedge clk);
    sar1_done = 1; @(negedge clk); sar1_done = 0;
    chk(hold_of(1) == 2'b01, "R3 dac1 up-shift", hold_of(1), 1);
    rst = 1; @(negedge clk); rst = 0;
    chk(all_low(), "R1 mid reset", 1, 0);
    @(negedge clk);
    conv(2, 0, 0, 0, 0, 0, 1'b0);  // R1: DAC 0 after reset

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (bench hung)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule